// File: doc/BRIEF.md
# I2C Master Address-Phase Sequencer

This block runs the addressing part of an I2C master transfer on top of a separate byte engine. A request captures a slave address, a 7-bit or 10-bit mode select and a transfer direction. The block then drives a series of commands to the engine: START, one or more address bytes, an optional repeated START, and STOP when needed. It waits for the engine to finish each command, reads the acknowledge result of each address byte, and ends with a one-cycle done pulse that carries a pass or fail verdict. The data bytes that follow the address, and the line-level signalling of each byte, belong to other blocks.

A 10-bit read is not sent as a single header. The block first sends the complete 10-bit write addressing (header with direction bit 0, then the low eight address bits). It then issues a repeated START and sends the header alone, this time with the direction bit set. A missing acknowledge on any address byte makes the block send a STOP and report failure. A fatal error from the engine ends the sequence at once, with no further commands. An abort request makes the block send a STOP and leaves a sticky flag set.

Top module: `i2c_addr_seq`

## Requirements
- R1: While reset is applied and in the first idle cycles after reset, `cmd_valid_o`, `done_o`, `pass_o`, `ack_err_o` and `abort_flag_o` are all 0.
- R2: Command opcodes on `cmd_op_o` are 0 = START, 1 = address byte, 2 = repeated START, 3 = STOP. The first command after an accepted request is always START.
- R3: In 7-bit mode (`ten_bit_i`=0), the single address byte is `{addr_i[6:0], rd_i}`, with read = 1 and write = 0. When it is acknowledged, the sequence ends with a pass.
- R4: In a 10-bit write, the block sends the header byte `{5'b11110, addr_i[9:8], 1'b0}` and then `addr_i[7:0]`. When both are acknowledged, the sequence ends with a pass.
- R5: In a 10-bit read, the block sends the R4 bytes, then a repeated START, then only the header `{5'b11110, addr_i[9:8], 1'b1}`. If every byte is acknowledged, the sequence ends with a pass.
- R6: When the engine reports a NACK (`eng_nack_i`=1 with `eng_done_i`) on an address byte, the next command is STOP. After the STOP completes, the block gives done with `pass_o`=0 and sets `ack_err_o`. In a 10-bit read this happens before any repeated START is sent. A NACK reported on a START or repeated START has no effect.
- R7: `ack_err_o` is cleared when a request is accepted.
- R8: When `eng_fatal_i` is seen while a command is outstanding, done with `pass_o`=0 follows in the next cycle, and no further command (not even STOP) is issued.
- R9: Asserting `abort_i` sets `abort_flag_o`. The flag stays set until the next accepted request. If a command is in flight, that command is allowed to complete, then STOP is issued and done with `pass_o`=0 follows. An abort while idle issues STOP and then done with `pass_o`=0.
- R10: If an abort and a NACK coincide on the same address byte, exactly one STOP is issued, and both `ack_err_o` and `abort_flag_o` are set.
- R11: A request raised while a sequence is in progress is ignored. The sequence keeps the address, mode and direction captured at acceptance.
- R12: A command stays valid and unchanged until the engine signals `eng_done_i` or `eng_fatal_i`. `done_o` is a one-cycle pulse in the cycle after the final command completes, and `pass_o` is meaningful only while `done_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Start an address phase (accepted only when idle) |
| ten_bit_i | input | 1 | 1 selects 10-bit addressing |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| addr_i | input | 10 | Slave address (bits 6:0 used in 7-bit mode) |
| abort_i | input | 1 | Abort request |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Verdict, valid with done_o |
| ack_err_o | output | 1 | An address byte was not acknowledged |
| abort_flag_o | output | 1 | Sticky abort indication |
| cmd_valid_o | output | 1 | Command to the byte engine is pending |
| cmd_op_o | output | 2 | Command opcode (see R2) |
| cmd_byte_o | output | 8 | Byte to send for opcode 1, zero otherwise |
| eng_done_i | input | 1 | Engine finished the pending command |
| eng_nack_i | input | 1 | With eng_done_i: byte not acknowledged |
| eng_fatal_i | input | 1 | Engine fatal error |

## Verification
The collision of interest is an abort arriving in the same cycle that the engine completes an address byte, either with an acknowledge or with a NACK. The bench's engine model raises `abort_i` together with `eng_done_i`, and in some runs also `eng_nack_i`. This is done for every command position, in both address modes and both directions. A separate variant raises the abort while the command is still in flight. The outcome is judged from the recorded command stream and the flags: one STOP exactly, no command after it, a failing verdict, and `ack_err_o` and `abort_flag_o` set to the values the bench computes for that position.

// File: rtl/i2c_aseq_pkg.sv
package i2c_aseq_pkg;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_START   = 2'd0,
    OP_BYTE    = 2'd1,
    OP_RESTART = 2'd2,
    OP_STOP    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_FIRST, S_LOW, S_RESTART, S_HDR_RD, S_STOP, S_FIN
  } state_e;

  typedef enum logic [1:0] {
    SEL_FIRST, SEL_LOW, SEL_HDR_RD
  } sel_e;
endpackage

// File: rtl/i2c_aseq_bytes.sv
module i2c_aseq_bytes
  import i2c_aseq_pkg::*;
#(
  parameter int                 TAG_W   = 5,
  parameter logic [TAG_W-1:0]   HDR_TAG = 5'b11110
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ten_bit_i,
  input  logic              rd_i,
  input  sel_e              sel_i,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [HI_W-1:0]   hi_bits;
  logic [BYTE_W-1:0] hdr_wr, hdr_rd, seven;

  always_comb begin
    hi_bits = addr_i[ADDR_W-1:BYTE_W];
    hdr_wr  = {HDR_TAG, hi_bits, 1'b0};
    hdr_rd  = {HDR_TAG, hi_bits, 1'b1};
    seven   = {addr_i[BYTE_W-2:0], rd_i};
    case (sel_i)
      SEL_FIRST:  byte_o = ten_bit_i ? hdr_wr : seven;
      SEL_LOW:    byte_o = addr_i[BYTE_W-1:0];
      SEL_HDR_RD: byte_o = hdr_rd;
      default:    byte_o = '0;
    endcase
  end

  always_comb begin
    if (sel_i == SEL_HDR_RD)
      a_r5_hdr_rd_bit: assert (byte_o[0] == 1'b1);
  end
endmodule

// File: rtl/i2c_aseq_flags.sv
module i2c_aseq_flags (
  input  logic clk,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_ack_i,
  input  logic set_abort_i,
  input  logic set_fail_i,
  output logic ack_err_o,
  output logic abort_o,
  output logic fail_o
);
  logic ack_d, abort_d, fail_d;

  always_comb begin
    ack_d   = clr_i ? 1'b0 : (ack_err_o | set_ack_i);
    abort_d = clr_i ? 1'b0 : (abort_o | set_abort_i);
    fail_d  = clr_i ? 1'b0 : (fail_o | set_fail_i);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_err_o <= 1'b0;
      abort_o   <= 1'b0;
      fail_o    <= 1'b0;
    end else begin
      ack_err_o <= ack_d;
      abort_o   <= abort_d;
      fail_o    <= fail_d;
    end
  end

  a_r7_ackerr_cleared: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> !ack_err_o);
  a_r9_abort_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (abort_o && !clr_i) |=> abort_o);
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_aseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              ten_bit_i,
  input  logic              rd_i,
  input  logic [9:0]        addr_i,
  input  logic              abort_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              ack_err_o,
  output logic              abort_flag_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_byte_o,
  input  logic              eng_done_i,
  input  logic              eng_nack_i,
  input  logic              eng_fatal_i
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  state_e              state_q, state_d, ok_next;
  logic                pend_q, pend_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                ten_q, rd_q;
  logic                accept, set_ack, set_fail, fatal_hit;
  logic                cmd_st, byte_st, abort_now, fail_q;
  sel_e                sel;
  logic [BYTE_W-1:0]   formed;

  // successor on a clean completion
  always_comb begin
    case (state_q)
      S_START:   ok_next = S_FIRST;
      S_FIRST:   ok_next = ten_q ? S_LOW : S_FIN;
      S_LOW:     ok_next = rd_q ? S_RESTART : S_FIN;
      S_RESTART: ok_next = S_HDR_RD;
      default:   ok_next = S_FIN;
    endcase
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    set_ack   = 1'b0;
    cmd_st    = state_q inside {S_START, S_FIRST, S_LOW, S_RESTART, S_HDR_RD, S_STOP};
    byte_st   = state_q inside {S_FIRST, S_LOW, S_HDR_RD};
    abort_now = abort_i | pend_q;
    fatal_hit = cmd_st & eng_fatal_i;
    case (state_q)
      S_IDLE: begin
        if (abort_now) state_d = S_STOP;
        else if (req_i) begin
          accept  = 1'b1;
          state_d = S_START;
        end
      end
      S_STOP: if (eng_done_i) state_d = S_FIN;
      S_FIN:  state_d = S_IDLE;
      default: begin
        if (eng_done_i) begin
          if (byte_st && eng_nack_i) begin
            set_ack = 1'b1;
            state_d = S_STOP;
          end else if (abort_now) begin
            state_d = S_STOP;
          end else begin
            state_d = ok_next;
          end
        end
      end
    endcase
    if (fatal_hit) begin
      state_d = S_FIN;
      set_ack = 1'b0;
    end
    set_fail = fatal_hit || (state_d == S_STOP && state_q != S_STOP);
    pend_d   = (pend_q | abort_i) & (state_q != S_STOP) & (state_d != S_STOP) & !fatal_hit;
  end

  // state and capture registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      ten_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= addr_i;
      ten_q  <= ten_bit_i;
      rd_q   <= rd_i;
    end
  end

  // command port
  always_comb begin
    case (state_q)
      S_LOW:    sel = SEL_LOW;
      S_HDR_RD: sel = SEL_HDR_RD;
      default:  sel = SEL_FIRST;
    endcase
    case (state_q)
      S_START:   cmd_op_o = OP_START;
      S_RESTART: cmd_op_o = OP_RESTART;
      S_STOP:    cmd_op_o = OP_STOP;
      default:   cmd_op_o = OP_BYTE;
    endcase
    cmd_valid_o = cmd_st;
    cmd_byte_o  = byte_st ? formed : '0;
  end

  i2c_aseq_bytes u_bytes (
    .addr_i    (addr_q),
    .ten_bit_i (ten_q),
    .rd_i      (rd_q),
    .sel_i     (sel),
    .byte_o    (formed)
  );

  i2c_aseq_flags u_flags (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .clr_i       (accept),
    .set_ack_i   (set_ack),
    .set_abort_i (abort_i),
    .set_fail_i  (set_fail),
    .ack_err_o   (ack_err_o),
    .abort_o     (abort_flag_o),
    .fail_o      (fail_q)
  );

  assign done_o = (state_q == S_FIN);
  assign pass_o = done_o & ~fail_q;

  a_r2_start_first: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> (cmd_valid_o && cmd_op_o == OP_START));
  a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_BYTE && eng_done_i && eng_nack_i && !eng_fatal_i)
      |=> (cmd_valid_o && cmd_op_o == OP_STOP));
  a_r8_fatal_silent: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid_o && eng_fatal_i) |=> (!cmd_valid_o && done_o && !pass_o));
  a_r10_one_stop: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_STOP && eng_done_i) |=> (!cmd_valid_o && done_o));
  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_valid_o && !eng_done_i && !eng_fatal_i)
      |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_byte_o)));
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/test_i2c_addr_seq.sv
module test_i2c_addr_seq;
  localparam int LAT = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, req_drv, req_mid, ten_bit, rd, abort_drv, abort_eng;
  logic [9:0] addr_drv;
  logic       eng_done, eng_nack, eng_fatal;
  logic       done_o, pass_o, ack_err_o, abort_flag_o, cmd_valid_o;
  logic [1:0] cmd_op_o;
  logic [7:0] cmd_byte_o;
  logic       req_i, abort_i;
  logic [9:0] addr_i;

  assign req_i   = req_drv | req_mid;
  assign abort_i = abort_drv | abort_eng;
  assign addr_i  = req_mid ? (addr_drv ^ 10'h3FF) : addr_drv;

  i2c_addr_seq i_i2c_addr_seq (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ten_bit_i(ten_bit), .rd_i(rd),
    .addr_i(addr_i), .abort_i(abort_i), .done_o(done_o), .pass_o(pass_o),
    .ack_err_o(ack_err_o), .abort_flag_o(abort_flag_o), .cmd_valid_o(cmd_valid_o),
    .cmd_op_o(cmd_op_o), .cmd_byte_o(cmd_byte_o), .eng_done_i(eng_done),
    .eng_nack_i(eng_nack), .eng_fatal_i(eng_fatal)
  );

  int n_chk = 0, n_fail = 0;
  int sc_kind = 0, sc_idx = 0;
  bit midreq = 0, unstable = 0;
  int log_n = 0;
  logic [1:0] log_op[16];
  logic [7:0] log_byte[16];
  int exp_n;
  logic [1:0] exp_op[8];
  logic [7:0] exp_byte[8];
  bit exp_pass, exp_ack, exp_abt;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // byte engine model
  initial begin
    abort_eng = 0; req_mid = 0; eng_done = 0; eng_nack = 0; eng_fatal = 0;
    forever begin
      @(negedge clk);
      if (cmd_valid_o) begin
        int idx;
        idx = log_n;
        if (idx < 16) begin
          log_op[idx] = cmd_op_o;
          log_byte[idx] = cmd_byte_o;
        end
        log_n++;
        for (int w = 0; w < LAT; w++) begin
          @(negedge clk);
          if (!cmd_valid_o || (idx < 16 && (cmd_op_o != log_op[idx] || cmd_byte_o != log_byte[idx])))
            unstable = 1;
          abort_eng = (w == 0 && sc_kind == 4 && idx == sc_idx);
          req_mid   = (w == 0 && midreq && idx == 0);
        end
        req_mid   = 0;
        abort_eng = ((sc_kind == 3 || sc_kind == 5) && idx == sc_idx);
        eng_nack  = ((sc_kind == 1 || sc_kind == 5) && idx == sc_idx);
        eng_fatal = (sc_kind == 2 && idx == sc_idx);
        eng_done  = 1;
        @(negedge clk);
        eng_done = 0; eng_nack = 0; eng_fatal = 0; abort_eng = 0;
      end
    end
  end

  task automatic build_exp(input bit ten, input bit rdv, input logic [9:0] a,
                           input int kind, input int idx);
    logic [1:0] nop[5];
    logic [7:0] nb[5];
    int nn;
    nop[0] = 2'd0; nb[0] = 8'h00;
    nop[1] = 2'd1;
    if (!ten) begin
      nb[1] = {a[6:0], rdv}; nn = 2;
    end else begin
      nb[1] = {5'b11110, a[9:8], 1'b0};
      nop[2] = 2'd1; nb[2] = a[7:0]; nn = 3;
      if (rdv) begin
        nop[3] = 2'd2; nb[3] = 8'h00;
        nop[4] = 2'd1; nb[4] = {5'b11110, a[9:8], 1'b1}; nn = 5;
      end
    end
    exp_n = 0; exp_pass = 1; exp_ack = 0; exp_abt = 0;
    for (int i = 0; i < nn; i++) begin
      exp_op[exp_n] = nop[i]; exp_byte[exp_n] = nb[i]; exp_n++;
      if (kind == 2 && i == idx) begin
        exp_pass = 0; break;
      end
      if ((kind == 1 || kind == 5) && i == idx && nop[i] == 2'd1) begin
        exp_ack = 1; exp_abt = (kind == 5); exp_pass = 0;
        exp_op[exp_n] = 2'd3; exp_byte[exp_n] = 8'h00; exp_n++; break;
      end
      if (kind >= 3 && i == idx) begin
        exp_abt = 1; exp_pass = 0;
        exp_op[exp_n] = 2'd3; exp_byte[exp_n] = 8'h00; exp_n++; break;
      end
    end
  endtask

  task automatic finish_and_compare(input string tag);
    bit gp, ga, gb, ok;
    int t;
    t = 0;
    while (!done_o && t < 300) begin
      @(negedge clk); t++;
    end
    check(done_o, {tag, " R12 done seen"}, done_o, 1);
    gp = pass_o; ga = ack_err_o; gb = abort_flag_o;
    repeat (4) @(negedge clk);
    check(gp == exp_pass, {tag, " verdict"}, gp, exp_pass);
    check(ga == exp_ack, {tag, " R6 R7 ack_err"}, ga, exp_ack);
    check(gb == exp_abt, {tag, " R9 abort flag"}, gb, exp_abt);
    check(log_n == exp_n, {tag, " R8 R11 command count"}, log_n, exp_n);
    ok = (log_n == exp_n);
    for (int i = 0; i < exp_n && i < 16; i++) begin
      if (log_op[i] != exp_op[i]) ok = 0;
      if (exp_op[i] == 2'd1 && log_byte[i] != exp_byte[i]) begin
        ok = 0;
        $display("  byte %0d got %0h want %0h", i, log_byte[i], exp_byte[i]);
      end
    end
    check(ok, {tag, " command stream"}, log_n, exp_n);
    check(!unstable, {tag, " R12 command held"}, unstable, 0);
  endtask

  task automatic run_txn(input bit ten, input bit rdv, input logic [9:0] a,
                         input int kind, input int idx, input bit mreq, input string tag);
    build_exp(ten, rdv, a, kind, idx);
    @(negedge clk);
    sc_kind = kind; sc_idx = idx; midreq = mreq; log_n = 0; unstable = 0;
    ten_bit = ten; rd = rdv; addr_drv = a; req_drv = 1;
    @(negedge clk);
    req_drv = 0;
    check(cmd_valid_o && cmd_op_o == 2'd0, {tag, " R2 first START"}, cmd_op_o, 0);
    finish_and_compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; req_drv = 0; ten_bit = 0; rd = 0; addr_drv = '0; abort_drv = 0;
    repeat (3) @(negedge clk);
    check(!cmd_valid_o && !done_o && !ack_err_o && !abort_flag_o && !pass_o,
          "R1 outputs in reset", {cmd_valid_o, done_o, ack_err_o, abort_flag_o}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!cmd_valid_o && !done_o && !ack_err_o && !abort_flag_o && !pass_o,
          "R1 outputs after reset", {cmd_valid_o, done_o, ack_err_o, abort_flag_o}, 0);

    // abort while idle: STOP then failing done
    sc_kind = 0; sc_idx = 0; midreq = 0; log_n = 0; unstable = 0;
    exp_n = 1; exp_op[0] = 2'd3; exp_byte[0] = 8'h00;
    exp_pass = 0; exp_ack = 0; exp_abt = 1;
    abort_drv = 1;
    @(negedge clk);
    abort_drv = 0;
    finish_and_compare("R9 idle abort");

    for (int k = 0; k < 6; k++) begin
      logic [9:0] a;
      a = (k == 0) ? 10'h000 : (k == 1) ? 10'h3FF : 10'((k * 293 + 17) % 1024);
      for (int m = 0; m < 4; m++) begin
        bit ten, rdv;
        int nn;
        string mt;
        ten = m[1]; rdv = m[0];
        nn = ten ? (rdv ? 5 : 3) : 2;
        mt = !ten ? "R3 7bit" : (rdv ? "R5 10bit-rd" : "R4 10bit-wr");
        run_txn(ten, rdv, a, 0, 0, k == 2, (k == 2) ? {mt, " R11 busy req"} : mt);
        for (int kind = 1; kind <= 5; kind++) begin
          for (int idx = 0; idx < nn; idx++) begin
            string kt;
            case (kind)
              1: kt = " R6 nack";
              2: kt = " R8 fatal";
              3: kt = " R9 abort on done";
              4: kt = " R9 abort in flight";
              default: kt = " R10 abort+nack";
            endcase
            run_txn(ten, rdv, a, kind, idx, 0, {mt, kt, $sformatf(" @%0d", idx)});
          end
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule